// File: doc/BRIEF.md
# Six-Instruction Single-Cycle Processor Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. In a single cycle it fetches a word from instruction memory, decodes it, reads two operands from a 32-entry register file, and computes a result in an add/subtract/OR unit. It then either reads or writes data memory. The register file, the program counter and data memory all take their new values on the same rising clock edge. Reads from the register file and from both memories are combinational.

The core decodes six operations: wrapping register add and subtract, OR with a zero-extended immediate, word load, word store, and branch-if-equal. Any other encoding only advances the program counter. Instruction and data memories sit outside the core. The instruction address is the program counter itself, so the surrounding logic can follow the order in which instructions retire.

Top module: `sixop_cpu_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter is loaded with 0 on that edge (synchronous reset). During reset, no register write and no memory write take effect.
- R2: Every instruction other than a taken branch advances the program counter by 4 on the next edge. This includes unrecognised encodings.
- R3: Register add is encoded as opcode bits [31:26] = 0 and funct bits [5:0] = 0x21. It writes rs+rt into rd (rs in bits [25:21], rt in [20:16], rd in [15:11]). The sum wraps modulo 2^32 and never traps.
- R4: Register subtract is encoded as opcode 0 and funct 0x23. It writes rs−rt, modulo 2^32, into rd.
- R5: OR-immediate is opcode 0x0D. It writes rs OR imm16 (bits [15:0], zero-extended) into rt.
- R6: Load is opcode 0x23. It drives `dataAddr` = rs + sign-extended imm16 and writes `dataRdData` into rt.
- R7: Store is opcode 0x2B. It drives `dataAddr` = rs + sign-extended imm16 and `dataWrData` = rt, and raises `dataWrEn`. No other instruction raises `dataWrEn`, and a store writes no register.
- R8: Branch-if-equal is opcode 0x04. When rs equals rt, the next program counter is PC+4+(sign-extended imm16 × 4), so negative offsets branch backwards. Otherwise the next program counter is PC+4.
- R9: Register 0 always reads as zero, and writes aimed at it are discarded.
- R10: An unrecognised opcode, or opcode 0 with a funct other than 0x21 or 0x23, changes no register and no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instrAddr | output | 32 | Program counter, used as the instruction memory byte address |
| instrWord | input | 32 | Instruction word read combinationally at `instrAddr` |
| dataAddr | output | 32 | Data memory byte address (ALU result) |
| dataWrData | output | 32 | Store data (second register operand) |
| dataWrEn | output | 1 | Data memory write strobe, taken on the rising edge |
| dataRdData | input | 32 | Data memory word read combinationally at `dataAddr` |

## Verification
Register contents cannot be seen at the ports. The test program therefore stores each result it computes to data memory, and register effects are judged from those stores. The hardest case to reach is the proof that writes to register 0, and writes from unrecognised encodings, had no effect. Data memory is first filled with a marker pattern. Register 0 and the register targeted by the ignored encodings are later stored, and the stored values must be zero and the earlier value respectively. Branch behaviour is checked through the program-counter trace: a taken branch skips an instruction that would overwrite a result, and a backward self-branch at the end must hold the program counter in place.

// File: rtl/cpu_core_pkg.sv
package cpu_core_pkg;

  localparam logic [5:0] OPC_REG   = 6'h00;
  localparam logic [5:0] OPC_ORIMM = 6'h0D;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BREQ  = 6'h04;
  localparam logic [5:0] FN_ADD    = 6'h21;
  localparam logic [5:0] FN_SUB    = 6'h23;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } aluOpT;

  // strobes from control to datapath
  typedef struct packed {
    logic  dstIsRd;     // write-back index from rd instead of rt
    logic  aluUsesImm;  // second ALU operand is the extended immediate
    logic  extSigned;   // sign extend the immediate
    aluOpT aluOp;
    logic  memWrite;
    logic  loadToReg;   // write-back from data memory
    logic  regWrite;
    logic  branchEq;    // take branch when operands match
  } ctrlT;

endpackage

// File: rtl/cpu_control.sv
module cpu_control
  import cpu_core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrlT       strobes
);

  always_comb begin
    strobes = '{dstIsRd: 1'b0, aluUsesImm: 1'b0, extSigned: 1'b0,
                aluOp: ALU_ADD, memWrite: 1'b0, loadToReg: 1'b0,
                regWrite: 1'b0, branchEq: 1'b0};
    unique case (opcode)
      OPC_REG: begin
        if (funct == FN_ADD) begin
          strobes.dstIsRd  = 1'b1;
          strobes.regWrite = 1'b1;
          strobes.aluOp    = ALU_ADD;
        end else if (funct == FN_SUB) begin
          strobes.dstIsRd  = 1'b1;
          strobes.regWrite = 1'b1;
          strobes.aluOp    = ALU_SUB;
        end
      end
      OPC_ORIMM: begin
        strobes.aluUsesImm = 1'b1;
        strobes.aluOp      = ALU_OR;
        strobes.regWrite   = 1'b1;
      end
      OPC_LOAD: begin
        strobes.aluUsesImm = 1'b1;
        strobes.extSigned  = 1'b1;
        strobes.loadToReg  = 1'b1;
        strobes.regWrite   = 1'b1;
      end
      OPC_STORE: begin
        strobes.aluUsesImm = 1'b1;
        strobes.extSigned  = 1'b1;
        strobes.memWrite   = 1'b1;
      end
      OPC_BREQ: begin
        strobes.extSigned = 1'b1;
        strobes.aluOp     = ALU_SUB;
        strobes.branchEq  = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic [IDX_W-1:0]  rdIdxB,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);

  localparam int DEPTH = 1 << IDX_W;

  // entry 0 is hardwired; only 1..DEPTH-1 hold state
  logic [DATA_W-1:0] regs [1:DEPTH-1];

  always_ff @(posedge clk) begin
    if (wrEn && (wrIdx != '0))
      regs[wrIdx] <= wrData;
  end

  assign rdDataA = (rdIdxA == '0) ? '0 : regs[rdIdxA];
  assign rdDataB = (rdIdxB == '0) ? '0 : regs[rdIdxB];

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_core_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  aluOpT             op,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              isZero
);

  always_comb begin
    unique case (op)
      ALU_SUB: result = opA - opB;
      ALU_OR:  result = opA | opB;
      default: result = opA + opB;
    endcase
  end

  assign isZero = (result == '0);

endmodule

// File: rtl/cpu_datapath.sv
module cpu_datapath
  import cpu_core_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          IDX_W    = 5,
  parameter int          IMM_W    = 16,
  parameter logic [31:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [25:0]       instrLow,
  input  ctrlT              strobes,
  input  logic [DATA_W-1:0] dataRdData,
  output logic [DATA_W-1:0] pc,
  output logic [DATA_W-1:0] dataAddr,
  output logic [DATA_W-1:0] dataWrData,
  output logic              dataWrEn
);

  localparam int EXT_W = DATA_W - IMM_W;

  logic [IDX_W-1:0]  fRs, fRt, fRd;
  logic [IMM_W-1:0]  fImm;
  logic [DATA_W-1:0] busA, busB, busW, immExt, aluB, aluOut;
  logic [DATA_W-1:0] pcPlus4, branchTarget, pcNext;
  logic [IDX_W-1:0]  wbIdx;
  logic              aluZero, takeBranch;

  assign fRs  = instrLow[25:21];
  assign fRt  = instrLow[20:16];
  assign fRd  = instrLow[15:11];
  assign fImm = instrLow[IMM_W-1:0];

  assign immExt = {{EXT_W{strobes.extSigned & fImm[IMM_W-1]}}, fImm};
  assign aluB   = strobes.aluUsesImm ? immExt : busB;
  assign wbIdx  = strobes.dstIsRd ? fRd : fRt;
  assign busW   = strobes.loadToReg ? dataRdData : aluOut;

  cpu_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
    .clk     (clk),
    .wrEn    (strobes.regWrite & ~rst),
    .rdIdxA  (fRs),
    .rdIdxB  (fRt),
    .wrIdx   (wbIdx),
    .wrData  (busW),
    .rdDataA (busA),
    .rdDataB (busB)
  );

  cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .op     (strobes.aluOp),
    .opA    (busA),
    .opB    (aluB),
    .result (aluOut),
    .isZero (aluZero)
  );

  // next-address logic
  assign pcPlus4      = pc + DATA_W'(4);
  assign branchTarget = pcPlus4 + (immExt << 2);
  assign takeBranch   = strobes.branchEq & aluZero;
  assign pcNext       = takeBranch ? branchTarget : pcPlus4;

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_PC[DATA_W-1:0];
    else     pc <= pcNext;
  end

  assign dataAddr   = aluOut;
  assign dataWrData = busB;
  assign dataWrEn   = strobes.memWrite & ~rst;

endmodule

// File: rtl/sixop_cpu_core.sv
module sixop_cpu_core
  import cpu_core_pkg::*;
#(
  parameter logic [31:0] RESET_PC = '0
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] instrAddr,
  input  logic [31:0] instrWord,
  output logic [31:0] dataAddr,
  output logic [31:0] dataWrData,
  output logic        dataWrEn,
  input  logic [31:0] dataRdData
);

  ctrlT strobes;

  cpu_control u_ctrl (
    .opcode  (instrWord[31:26]),
    .funct   (instrWord[5:0]),
    .strobes (strobes)
  );

  cpu_datapath #(.DATA_W(32), .IDX_W(5), .IMM_W(16), .RESET_PC(RESET_PC)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .instrLow   (instrWord[25:0]),
    .strobes    (strobes),
    .dataRdData (dataRdData),
    .pc         (instrAddr),
    .dataAddr   (dataAddr),
    .dataWrData (dataWrData),
    .dataWrEn   (dataWrEn)
  );

endmodule

// File: rtl/cpu_core_checker.sv
module cpu_core_checker #(
  parameter logic [31:0] RESET_PC = '0
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] instrAddr,
  input logic [31:0] instrWord,
  input logic [31:0] dataWrData,
  input logic        dataWrEn
);

  logic [5:0]  op;
  logic [31:0] brOffset;
  logic        knownOp;

  assign op       = instrWord[31:26];
  assign brOffset = {{14{instrWord[15]}}, instrWord[15:0], 2'b00};
  assign knownOp  = (op == 6'h00) || (op == 6'h0D) || (op == 6'h23) ||
                    (op == 6'h2B) || (op == 6'h04);

  // R1
  p_reset_pc_r1: assert property (@(posedge clk)
    rst |=> (instrAddr == RESET_PC));

  // R2
  p_seq_pc_r2: assert property (@(posedge clk) disable iff (rst)
    (op != 6'h04) |=> (instrAddr == $past(instrAddr) + 32'd4));

  // R8: identical register fields always compare equal
  p_branch_same_r8: assert property (@(posedge clk) disable iff (rst)
    ((op == 6'h04) && (instrWord[25:21] == instrWord[20:16]))
      |=> (instrAddr == $past(instrAddr) + 32'd4 + $past(brOffset)));

  // R7
  p_store_only_r7: assert property (@(posedge clk) disable iff (rst)
    dataWrEn |-> (op == 6'h2B));

  // R9
  p_zero_reg_r9: assert property (@(posedge clk) disable iff (rst)
    ((op == 6'h2B) && (instrWord[20:16] == 5'd0)) |-> (dataWrData == 32'd0));

  // R10
  p_unknown_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!knownOp) |-> !dataWrEn);

endmodule

bind sixop_cpu_core cpu_core_checker #(.RESET_PC(RESET_PC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .instrAddr  (instrAddr),
  .instrWord  (instrWord),
  .dataWrData (dataWrData),
  .dataWrEn   (dataWrEn)
);

// File: tb/sixop_cpu_core_test.sv
module sixop_cpu_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instrAddr, instrWord, dataAddr, dataWrData, dataRdData;
  logic        dataWrEn;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  int          nChecks = 0;
  int          nFails  = 0;
  int          nWrites = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sixop_cpu_core uut (
    .clk        (clk),
    .rst        (rst),
    .instrAddr  (instrAddr),
    .instrWord  (instrWord),
    .dataAddr   (dataAddr),
    .dataWrData (dataWrData),
    .dataWrEn   (dataWrEn),
    .dataRdData (dataRdData)
  );

  assign instrWord  = imem[instrAddr[7:2]];
  assign dataRdData = dmem[dataAddr[7:2]];

  always @(posedge clk) begin
    if (dataWrEn) begin
      dmem[dataAddr[7:2]] <= dataWrData;
      nWrites <= nWrites + 1;
    end
  end

  function automatic logic [31:0] encR(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] encI(logic [5:0] opc, int rs, int rt, logic [15:0] imm);
    return {opc, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [5:0]  idx;
    logic [31:0] val;
    logic [3:0]  req;
  } memCheckT;

  localparam memCheckT MEM_CHECKS [11] = '{
    '{6'd16, 32'h0000_1234, 4'd10}, // R10: r1 survives ignored encodings
    '{6'd17, 32'h0000_FFFF, 4'd5},  // R5: zero-extended immediate
    '{6'd18, 32'h0001_1233, 4'd3},  // R3
    '{6'd19, 32'hFFFF_1235, 4'd4},  // R4
    '{6'd20, 32'hFFFF_FFFF, 4'd4},  // R4: 0 - 1 wraps
    '{6'd21, 32'h0000_0000, 4'd3},  // R3: wrap, no trap
    '{6'd22, 32'h0000_0000, 4'd9},  // R9
    '{6'd23, 32'hCAFE_F00D, 4'd6},  // R6: negative offset load
    '{6'd24, 32'h0000_00A1, 4'd8},  // R8: taken branch skipped overwrite
    '{6'd25, 32'hDEAD_BEEF, 4'd7},  // R7: untouched word
    '{6'd14, 32'hDEAD_BEEF, 4'd7}   // R7: untouched word
  };

  function automatic logic [31:0] expPc(int k);
    if (k <= 15) return 32'(4 * k);
    return (4 * (k + 1) < 104) ? 32'(4 * (k + 1)) : 32'd104;
  endfunction

  initial begin
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'd0;
      dmem[i] = 32'hDEAD_BEEF;
    end
    dmem[15] = 32'hCAFE_F00D;
    imem[0]  = encI(6'h0D, 0, 1, 16'h1234);
    imem[1]  = encI(6'h0D, 0, 2, 16'hFFFF);
    imem[2]  = encR(1, 2, 3, 6'h21);
    imem[3]  = encR(1, 2, 4, 6'h23);
    imem[4]  = encI(6'h0D, 0, 7, 16'h0001);
    imem[5]  = encR(0, 7, 6, 6'h23);
    imem[6]  = encR(6, 7, 8, 6'h21);
    imem[7]  = encI(6'h0D, 0, 0, 16'h0055);   // R9 write to r0
    imem[8]  = encR(1, 1, 0, 6'h21);          // R9 write to r0
    imem[9]  = encI(6'h0D, 0, 9, 16'h0040);
    imem[10] = encI(6'h3F, 0, 1, 16'h7777);   // R10 unknown opcode
    imem[11] = encR(2, 2, 1, 6'h20);          // R10 unknown funct
    imem[12] = encI(6'h23, 9, 10, 16'hFFFC);
    imem[13] = encI(6'h04, 1, 2, 16'h0001);   // not taken
    imem[14] = encI(6'h0D, 0, 11, 16'h00A1);
    imem[15] = encI(6'h04, 1, 1, 16'h0001);   // taken
    imem[16] = encI(6'h0D, 0, 11, 16'h00B2);
    imem[17] = encI(6'h2B, 9, 1, 16'd0);
    imem[18] = encI(6'h2B, 9, 2, 16'd4);
    imem[19] = encI(6'h2B, 9, 3, 16'd8);
    imem[20] = encI(6'h2B, 9, 4, 16'd12);
    imem[21] = encI(6'h2B, 9, 6, 16'd16);
    imem[22] = encI(6'h2B, 9, 8, 16'd20);
    imem[23] = encI(6'h2B, 9, 0, 16'd24);
    imem[24] = encI(6'h2B, 9, 10, 16'd28);
    imem[25] = encI(6'h2B, 9, 11, 16'd32);
    imem[26] = encI(6'h04, 0, 0, 16'hFFFF);   // backward self-branch

    repeat (2) @(posedge clk);
    @(negedge clk);
    check(instrAddr == 32'd0, "R1 reset pc", instrAddr, 32'd0);
    check(dataWrEn == 1'b0, "R1 no write in reset", 32'(dataWrEn), 32'd0);
    rst = 1'b0;

    // R2 and R8: program counter trace
    for (int k = 0; k < 36; k++) begin
      check(instrAddr == expPc(k), "R2/R8 pc trace", instrAddr, expPc(k));
      @(negedge clk);
    end

    // result vectors
    for (int i = 0; i < 11; i++) begin
      string tag;
      tag = $sformatf("R%0d mem[%0d]", MEM_CHECKS[i].req, MEM_CHECKS[i].idx);
      check(dmem[MEM_CHECKS[i].idx] == MEM_CHECKS[i].val, tag,
            dmem[MEM_CHECKS[i].idx], MEM_CHECKS[i].val);
    end
    check(nWrites == 9, "R7 store count", 32'(nWrites), 32'd9);

    // R1: synchronous reset from a running state
    rst = 1'b1;
    #1;
    check(instrAddr == 32'd104, "R1 pc held before edge", instrAddr, 32'd104);
    @(negedge clk);
    check(instrAddr == 32'd0, "R1 pc after reset edge", instrAddr, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(instrAddr == 32'd4, "R2 pc after release", instrAddr, 32'd4);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule